// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core that runs in seven operating modes. Software in every mode addresses sixteen general registers through a 4-bit index, and the file steers each access to one of 31 physical 32-bit registers according to the mode on `mode_i`. The low eight indices and the program counter (index 15) are common to all modes. The fast-interrupt mode owns private copies of indices 8 to 14. Every other exception mode owns only its own stack pointer (13) and link register (14). User and system modes share one set.

Status is held in one current status register and five saved status registers, one for each exception mode. The core writes status through a byte-masked write, which lets it change only the control byte and keep the condition flags. It can also write the four flags on their own when an instruction sets flags. A single-cycle exception entry changes the mode, raises the interrupt masks, saves the old status into the target mode's saved register, and writes the program counter into the target mode's link register. A separate link strobe performs the same link write for branch-with-link.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 reach the same physical register in every mode.
- R2: In fast-interrupt mode (10001), indices 8 to 12 reach private registers. All other modes share one set of indices 8 to 12.
- R3: Indices 13 and 14 are private to each of fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) mode. User (10000) and system (11111) share one pair, and any other mode code behaves as user.
- R4: Index 15 is the program counter and is the same register in every mode.
- R5: Both read ports are combinational. A write lands on the rising clock edge, so a read of the written register in the same cycle returns the old value.
- R6: `link_i` writes the current program counter into index 14 of the bank chosen by `mode_i`. When the general write targets the same register in the same cycle, the link write wins.
- R7: Reset clears all general registers to zero and sets the current and all saved status registers to 0x000000D3: supervisor mode, with bit 7 (interrupt mask) and bit 6 (fast-interrupt mask) set.
- R8: A status write replaces only the bytes enabled in `psr_mask_i` (bit n enables byte n). With mask 0001, bits 31:8, including the flags in 31:28, keep their value.
- R9: The flags in bits 31:28 of the current status take `flags_i` only in a cycle where `flags_wr_i` is high, and they override a status write in the same cycle. Otherwise they hold.
- R10: `spsr_o` shows the saved status of the mode on `mode_i` and reads zero in user or system mode. A saved-status write in user or system mode has no effect.
- R11: Exception entry (`exc_en_i` with an exception mode code) completes in one cycle. The target's saved status receives the old current status, the mode field takes the target code, and bit 7 is set (bit 6 too for fast-interrupt). The other status bits are kept, and the target's index 14 receives the program counter. A status or flag write in the same cycle is dropped. An entry with a non-exception code changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Mode code selecting the bank for reads, writes, link and saved status |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | General register write index |
| wr_data_i | input | 32 | General register write data |
| link_i | input | 1 | Copy program counter into the current bank's index 14 |
| psr_wr_en_i | input | 1 | Status write enable |
| psr_sel_i | input | 1 | 0 = current status, 1 = saved status of mode_i |
| psr_mask_i | input | 4 | Byte enables of the status write |
| psr_wdata_i | input | 32 | Status write data |
| flags_wr_i | input | 1 | Set-flags qualifier |
| flags_i | input | 4 | New flags for bits 31:28 |
| exc_en_i | input | 1 | Exception entry strobe |
| exc_mode_i | input | 5 | Target mode of the exception |
| cpsr_o | output | 32 | Current status register |
| spsr_o | output | 32 | Saved status of mode_i, zero if none |

## Verification
The bench writes through one mode and reads through another. Each read is chosen so that a wrong bank decode gives a value that can be seen: a file that shares fast-interrupt indices 8 to 12, or that splits user from system, returns data written in the other mode instead of zero, or zero instead of that data. It drives a link and a general write to the same register in one cycle, where a file with the wrong priority keeps the general data. It also checks that a same-cycle read still shows the old value. On the status side, it issues a control-byte write and a flag write with the qualifier low, and a file that leaks into the flags shows changed bits 31:28. It issues saved-status writes in user mode, which must be dropped. It enters two exceptions in a row, where a wrong order of the save would store the new status instead of the old one.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int XLEN    = 32;
  localparam int IDX_W   = 4;
  localparam int MODE_W  = 5;
  localparam int NPHYS   = 31;
  localparam int PHYS_W  = $clog2(NPHYS);
  localparam int NSAVED  = 5;
  localparam int SLOT_W  = $clog2(NSAVED);
  localparam int PSR_I   = 7;
  localparam int PSR_F   = 6;
  localparam logic [XLEN-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  // slot index of a saved status register equals bank - 1
  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  function automatic bank_e mode_to_bank(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_USR;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] merge_bytes(logic [XLEN-1:0] old_v,
                                                  logic [XLEN-1:0] new_v,
                                                  logic [XLEN/8-1:0] mask);
    logic [XLEN-1:0] r;
    r = old_v;
    for (int b = 0; b < XLEN/8; b++)
      if (mask[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import banked_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int PW = PHYS_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [IW-1:0]     idx_i,
  output logic [PW-1:0]     phys_o
);
  bank_e bank;
  logic  is_hi;   // 8..14
  logic  is_sl;   // 13..14

  assign bank  = mode_to_bank(mode_i);
  assign is_hi = (idx_i >= IW'(8)) && (idx_i <= IW'(14));
  assign is_sl = (idx_i == IW'(13)) || (idx_i == IW'(14));

  always_comb begin
    phys_o = PW'(idx_i);
    if (bank == BANK_FIQ && is_hi) begin
      phys_o = PW'(idx_i) + PW'(8);
    end else if (is_sl) begin
      case (bank)
        BANK_IRQ: phys_o = PW'(idx_i) + PW'(10);
        BANK_SVC: phys_o = PW'(idx_i) + PW'(12);
        BANK_ABT: phys_o = PW'(idx_i) + PW'(14);
        BANK_UND: phys_o = PW'(idx_i) + PW'(16);
        default:  phys_o = PW'(idx_i);
      endcase
    end
  end
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array
  import banked_rf_pkg::*;
#(
  parameter int DW  = XLEN,
  parameter int NP  = NPHYS,
  parameter int PW  = PHYS_W,
  parameter int NRD = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NRD-1:0][PW-1:0]  rd_phys_i,
  output logic [NRD-1:0][DW-1:0]  rd_data_o,
  input  logic                    wa_en_i,
  input  logic [PW-1:0]           wa_phys_i,
  input  logic [DW-1:0]           wa_data_i,
  input  logic                    wb_en_i,
  input  logic [PW-1:0]           wb_phys_i,
  input  logic [DW-1:0]           wb_data_i
);
  logic [DW-1:0] mem_q [NP];

  for (genvar g = 0; g < NP; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (wb_en_i && wb_phys_i == PW'(g))   mem_q[g] <= wb_data_i;
      else if (wa_en_i && wa_phys_i == PW'(g))   mem_q[g] <= wa_data_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = (rd_phys_i[r] < PW'(NP)) ? mem_q[rd_phys_i[r]] : '0;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && !(wb_en_i && wb_phys_i == wa_phys_i) && wa_phys_i < PW'(NP))
      |=> mem_q[$past(wa_phys_i)] == $past(wa_data_i)); // R5
  AST_LINK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_i && wb_phys_i < PW'(NP))
      |=> mem_q[$past(wb_phys_i)] == $past(wb_data_i)); // R6
endmodule

// File: rtl/rf_psr_unit.sv
module rf_psr_unit
  import banked_rf_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NS = NSAVED,
  parameter int SW = SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              psr_wr_en_i,
  input  logic              psr_sel_i,
  input  logic [DW/8-1:0]   psr_mask_i,
  input  logic [DW-1:0]     psr_wdata_i,
  input  logic              flags_wr_i,
  input  logic [3:0]        flags_i,
  input  logic              exc_en_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  output logic              exc_take_o,
  output logic [DW-1:0]     cpsr_o,
  output logic [DW-1:0]     spsr_o
);
  logic [DW-1:0] cpsr_q, cpsr_d;
  logic [DW-1:0] spsr_q [NS];
  bank_e         cur_bank, exc_bank;
  logic [SW-1:0] cur_slot, exc_slot;
  logic          has_spsr;

  assign cur_bank   = mode_to_bank(mode_i);
  assign exc_bank   = mode_to_bank(exc_mode_i);
  assign has_spsr   = (cur_bank != BANK_USR);
  assign cur_slot   = SW'(cur_bank) - SW'(1);
  assign exc_slot   = SW'(exc_bank) - SW'(1);
  assign exc_take_o = exc_en_i && (exc_bank != BANK_USR);

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_take_o) begin
      cpsr_d[MODE_W-1:0] = exc_mode_i;
      cpsr_d[PSR_I]      = 1'b1;
      if (exc_bank == BANK_FIQ) cpsr_d[PSR_F] = 1'b1;
    end else begin
      if (psr_wr_en_i && !psr_sel_i) cpsr_d = merge_bytes(cpsr_q, psr_wdata_i, psr_mask_i);
      if (flags_wr_i)                cpsr_d[DW-1 -: 4] = flags_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpsr_q <= PSR_RESET;
    else         cpsr_q <= cpsr_d;
  end

  for (genvar s = 0; s < NS; s++) begin : g_saved
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        spsr_q[s] <= PSR_RESET;
      else if (exc_take_o && exc_slot == SW'(s))
        spsr_q[s] <= cpsr_q;
      else if (!exc_take_o && psr_wr_en_i && psr_sel_i && has_spsr && cur_slot == SW'(s))
        spsr_q[s] <= merge_bytes(spsr_q[s], psr_wdata_i, psr_mask_i);
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = has_spsr ? spsr_q[cur_slot] : '0;

  AST_CTRL_WRITE_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_wr_en_i && !psr_sel_i && psr_mask_i == 4'b0001 && !flags_wr_i && !exc_en_i)
      |=> cpsr_q[DW-1:8] == $past(cpsr_q[DW-1:8])); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_wr_i && !(psr_wr_en_i && !psr_sel_i && psr_mask_i[DW/8-1]))
      |=> cpsr_q[DW-1 -: 4] == $past(cpsr_q[DW-1 -: 4])); // R9
  AST_EXC_MODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |=> (cpsr_q[MODE_W-1:0] == $past(exc_mode_i)) && cpsr_q[PSR_I]); // R11
  AST_EXC_SAVES_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |=> spsr_q[$past(exc_slot)] == $past(cpsr_q)); // R11
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IDX_WD = IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [IDX_WD-1:0]   rd_a_idx_i,
  output logic [DATA_W-1:0]   rd_a_data_o,
  input  logic [IDX_WD-1:0]   rd_b_idx_i,
  output logic [DATA_W-1:0]   rd_b_data_o,
  input  logic                wr_en_i,
  input  logic [IDX_WD-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                link_i,
  input  logic                psr_wr_en_i,
  input  logic                psr_sel_i,
  input  logic [DATA_W/8-1:0] psr_mask_i,
  input  logic [DATA_W-1:0]   psr_wdata_i,
  input  logic                flags_wr_i,
  input  logic [3:0]          flags_i,
  input  logic                exc_en_i,
  input  logic [MODE_W-1:0]   exc_mode_i,
  output logic [DATA_W-1:0]   cpsr_o,
  output logic [DATA_W-1:0]   spsr_o
);
  localparam int NMAP   = 5;   // rd a, rd b, write, link, exception link
  localparam int NRD    = 3;   // rd a, rd b, pc
  localparam int PW     = PHYS_W;
  localparam int PC_IDX = 15;
  localparam int LR_IDX = 14;

  logic [NMAP-1:0][MODE_W-1:0] map_mode;
  logic [NMAP-1:0][IDX_WD-1:0] map_idx;
  logic [NMAP-1:0][PW-1:0]     map_phys;
  logic [NRD-1:0][PW-1:0]      rd_phys;
  logic [NRD-1:0][DATA_W-1:0]  rd_data;
  logic                        exc_take;
  logic                        wb_en;
  logic [PW-1:0]               wb_phys;

  assign map_mode = {exc_mode_i, mode_i, mode_i, mode_i, mode_i};
  assign map_idx  = {IDX_WD'(LR_IDX), IDX_WD'(LR_IDX), wr_idx_i, rd_b_idx_i, rd_a_idx_i};

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rf_bank_map #(.IW(IDX_WD), .PW(PW)) u_map (
      .mode_i (map_mode[m]),
      .idx_i  (map_idx[m]),
      .phys_o (map_phys[m])
    );
  end

  assign rd_phys = {PW'(PC_IDX), map_phys[1], map_phys[0]};

  // exception link outranks branch link
  assign wb_en   = exc_take || link_i;
  assign wb_phys = exc_take ? map_phys[4] : map_phys[3];

  rf_gpr_array #(.DW(DATA_W), .NP(NPHYS), .PW(PW), .NRD(NRD)) u_gpr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_phys_i (rd_phys),
    .rd_data_o (rd_data),
    .wa_en_i   (wr_en_i),
    .wa_phys_i (map_phys[2]),
    .wa_data_i (wr_data_i),
    .wb_en_i   (wb_en),
    .wb_phys_i (wb_phys),
    .wb_data_i (rd_data[2])
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  rf_psr_unit #(.DW(DATA_W), .NS(NSAVED), .SW(SLOT_W)) u_psr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .psr_wr_en_i (psr_wr_en_i),
    .psr_sel_i   (psr_sel_i),
    .psr_mask_i  (psr_mask_i),
    .psr_wdata_i (psr_wdata_i),
    .flags_wr_i  (flags_wr_i),
    .flags_i     (flags_i),
    .exc_en_i    (exc_en_i),
    .exc_mode_i  (exc_mode_i),
    .exc_take_o  (exc_take),
    .cpsr_o      (cpsr_o),
    .spsr_o      (spsr_o)
  );
endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b00000;

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  wm;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [4:0]  rm;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1, M_USR, 4'd3,  32'h1111_0003, M_FIQ, 32'h1111_0003}, // R1
    '{4'd2, M_FIQ, 4'd9,  32'h2222_0009, M_USR, 32'h0000_0000}, // R2
    '{4'd2, M_USR, 4'd9,  32'h3333_0009, M_IRQ, 32'h3333_0009}, // R2
    '{4'd2, M_SVC, 4'd10, 32'h4444_000A, M_FIQ, 32'h0000_0000}, // R2
    '{4'd3, M_IRQ, 4'd13, 32'h5555_000D, M_SVC, 32'h0000_0000}, // R3
    '{4'd3, M_SYS, 4'd13, 32'h6666_000D, M_USR, 32'h6666_000D}, // R3
    '{4'd3, M_ABT, 4'd14, 32'h7777_000E, M_UND, 32'h0000_0000}, // R3
    '{4'd3, M_UND, 4'd14, 32'h8888_000E, M_UND, 32'h8888_000E}, // R3
    '{4'd3, M_BAD, 4'd13, 32'h9999_000D, M_USR, 32'h9999_000D}, // R3
    '{4'd4, M_FIQ, 4'd15, 32'h0000_1000, M_ABT, 32'h0000_1000}, // R4
    '{4'd3, M_SVC, 4'd13, 32'hAAAA_000D, M_IRQ, 32'h5555_000D}, // R3
    '{4'd1, M_USR, 4'd0,  32'hBBBB_0000, M_SYS, 32'hBBBB_0000}  // R1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode_i = M_USR;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, link_i = 1'b0;
  logic        psr_wr_en_i = 1'b0, psr_sel_i = 1'b0;
  logic [3:0]  psr_mask_i = '0;
  logic [31:0] psr_wdata_i = '0;
  logic        flags_wr_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        exc_en_i = 1'b0;
  logic [4:0]  exc_mode_i = M_USR;
  logic [31:0] cpsr_o, spsr_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  banked_regfile dut_i (
    .clk_i, .rst_ni, .mode_i,
    .rd_a_idx_i, .rd_a_data_o, .rd_b_idx_i, .rd_b_data_o,
    .wr_en_i, .wr_idx_i, .wr_data_i, .link_i,
    .psr_wr_en_i, .psr_sel_i, .psr_mask_i, .psr_wdata_i,
    .flags_wr_i, .flags_i, .exc_en_i, .exc_mode_i,
    .cpsr_o, .spsr_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [4:0] m, input logic [3:0] idx);
    mode_i = m; rd_a_idx_i = idx; rd_b_idx_i = idx; #1;
  endtask

  task automatic psr_write(input logic sel, input logic [3:0] mask, input logic [31:0] d);
    @(negedge clk_i);
    psr_wr_en_i = 1'b1; psr_sel_i = sel; psr_mask_i = mask; psr_wdata_i = d;
    @(negedge clk_i);
    psr_wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    read_at(M_SVC, 4'd5);
    check("R7 cpsr", cpsr_o, 32'h0000_00D3);
    check("R7 spsr", spsr_o, 32'h0000_00D3);
    check("R7 gpr", rd_a_data_o, 32'h0);
    read_at(M_USR, 4'd5);
    check("R10 user spsr", spsr_o, 32'h0);

    // banking table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      mode_i = VEC[i].wm; wr_en_i = 1'b1; wr_idx_i = VEC[i].idx; wr_data_i = VEC[i].data;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      read_at(VEC[i].rm, VEC[i].idx);
      check($sformatf("R%0d vec%0d a", VEC[i].req, i), rd_a_data_o, VEC[i].exp);
      check($sformatf("R%0d vec%0d b", VEC[i].req, i), rd_b_data_o, VEC[i].exp);
    end

    // R5 read during write
    @(negedge clk_i);
    mode_i = M_USR; rd_a_idx_i = 4'd2;
    wr_en_i = 1'b1; wr_idx_i = 4'd2; wr_data_i = 32'hCAFE_0002; #1;
    check("R5 old value", rd_a_data_o, 32'h0);
    @(negedge clk_i);
    wr_en_i = 1'b0; #1;
    check("R5 new value", rd_a_data_o, 32'hCAFE_0002);

    // R6 link beats general write
    @(negedge clk_i);
    mode_i = M_IRQ; link_i = 1'b1;
    wr_en_i = 1'b1; wr_idx_i = 4'd14; wr_data_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    link_i = 1'b0; wr_en_i = 1'b0;
    read_at(M_IRQ, 4'd14);
    check("R6 irq lr", rd_a_data_o, 32'h0000_1000);
    read_at(M_USR, 4'd14);
    check("R6 user lr untouched", rd_a_data_o, 32'h0);

    // R8 masked status writes
    mode_i = M_SVC;
    psr_write(1'b0, 4'b0001, 32'hFFFF_FF1F);
    #1; check("R8 ctrl only", cpsr_o, 32'h0000_001F);
    psr_write(1'b0, 4'b1000, 32'hA000_0000);
    #1; check("R8 top byte", cpsr_o, 32'hA000_001F);

    // R9 flag qualifier
    @(negedge clk_i);
    flags_i = 4'b0101; flags_wr_i = 1'b0;
    @(negedge clk_i); #1;
    check("R9 no qualifier", cpsr_o, 32'hA000_001F);
    flags_wr_i = 1'b1;
    @(negedge clk_i);
    flags_wr_i = 1'b0; #1;
    check("R9 qualifier", cpsr_o, 32'h5000_001F);

    // R10 saved status only in exception modes
    mode_i = M_USR;
    psr_write(1'b1, 4'b1111, 32'h1234_5678);
    #1; check("R10 user spsr zero", spsr_o, 32'h0);
    read_at(M_SVC, 4'd0);
    check("R10 user write dropped", spsr_o, 32'h0000_00D3);
    mode_i = M_ABT;
    psr_write(1'b1, 4'b1111, 32'h0123_4567);
    #1; check("R10 abt spsr", spsr_o, 32'h0123_4567);
    read_at(M_SVC, 4'd0);
    check("R10 svc spsr kept", spsr_o, 32'h0000_00D3);

    // R11 exception entry
    @(negedge clk_i);
    exc_en_i = 1'b1; exc_mode_i = M_FIQ;
    @(negedge clk_i);
    exc_en_i = 1'b0; #1;
    check("R11 fiq cpsr", cpsr_o, 32'h5000_00D1);
    read_at(M_FIQ, 4'd14);
    check("R11 fiq spsr", spsr_o, 32'h5000_001F);
    check("R11 fiq lr", rd_a_data_o, 32'h0000_1000);

    @(negedge clk_i);
    mode_i = M_FIQ; wr_en_i = 1'b1; wr_idx_i = 4'd15; wr_data_i = 32'h0000_2000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    exc_en_i = 1'b1; exc_mode_i = M_IRQ;
    psr_wr_en_i = 1'b1; psr_sel_i = 1'b0; psr_mask_i = 4'hF; psr_wdata_i = 32'h0;
    flags_wr_i = 1'b1; flags_i = 4'b1111;
    @(negedge clk_i);
    exc_en_i = 1'b0; psr_wr_en_i = 1'b0; flags_wr_i = 1'b0; #1;
    check("R11 irq cpsr, writes dropped", cpsr_o, 32'h5000_00D2);
    read_at(M_IRQ, 4'd14);
    check("R11 irq spsr", spsr_o, 32'h5000_00D1);
    check("R11 irq lr", rd_a_data_o, 32'h0000_2000);
    read_at(M_FIQ, 4'd14);
    check("R11 fiq spsr kept", spsr_o, 32'h5000_001F);

    @(negedge clk_i);
    exc_en_i = 1'b1; exc_mode_i = M_USR;
    @(negedge clk_i);
    exc_en_i = 1'b0; #1;
    check("R11 non-exception entry ignored", cpsr_o, 32'h5000_00D2);
    read_at(M_USR, 4'd14);
    check("R11 user lr untouched", rd_a_data_o, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule